// File: doc/BRIEF.md
# Framed 24-bit Serial Command Receiver

This block takes command words from a three-wire serial link (active-low select, serial clock, data) and turns every complete 24-bit word into one write into a 16-entry, 16-bit channel memory. The three link pins are brought into the system clock domain and their edges are found there. One select frame may hold any number of words. Each word is committed when its own 24th bit arrives.

Each word carries two mode bits. The receiver keeps the bits from the most recent word and ORs each one with an external pin: a 1 on either side wins. The results are an immediate-update flag and an external-sequencer-clock flag. A refresh sequencer receives a frame-active level and a one-cycle word-done pulse, which carries the channel address and the immediate flag. While a reset fill of the memory is running, the receiver ignores the link completely.

Top module: `serial_cmd_rx`

## Requirements
- R1: Bits are taken on rising serial-clock edges while select is low, most significant bit first. The first rising edge after select falls carries bit 23.
- R2: Word fields: bits 23..8 are the write data, bits 7..4 the channel address, bit 3 a reserved zero, bit 2 the immediate mode bit, bit 1 the external-clock mode bit, and bit 0 a fill zero.
- R3: An address field of value n writes memory entry n, with `mem_addr` = n and `mem_wdata` = the data field.
- R4: Every complete 24-bit word gives exactly one single-cycle `mem_we` pulse, together with `word_done`. Several words sent back to back in one frame give one write each, in order.
- R5: Bits left over when select rises, fewer than 24, are discarded without a write. The bit count starts from zero in every new frame.
- R6: `imm_eff` is the immediate bit of the last committed word ORed with `imm_pin`. `word_imm` reports that OR for the word being written. The stored bit changes only when a word is committed.
- R7: `xclk_eff` is the external-clock bit of the last committed word ORed with `xclk_pin`. A word with that bit at 0 deselects the clock again.
- R8: The values of the reserved bit and the fill bit have no effect on the data, the address or the mode flags.
- R9: While `fill_busy` is high, the link is ignored. No write occurs, the stored mode bits do not change, and `frame_active` stays low.
- R10: `frame_active` is high while select is low and no fill is running, and it is low otherwise.
- R11: After reset, `mem_we`, `word_done`, `frame_active`, `imm_eff` and `xclk_eff` are all low when the mode pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Link select, active low, asynchronous |
| sck | input | 1 | Link serial clock, asynchronous |
| sdi | input | 1 | Link serial data, asynchronous |
| imm_pin | input | 1 | External immediate-update request |
| xclk_pin | input | 1 | External sequencer-clock select |
| fill_busy | input | 1 | High while a reset fill owns the memory |
| mem_we | output | 1 | Memory write strobe, one cycle per word |
| mem_addr | output | 4 | Memory entry to write |
| mem_wdata | output | 16 | Data to write |
| imm_eff | output | 1 | Effective immediate-update flag |
| xclk_eff | output | 1 | Effective external-clock flag |
| frame_active | output | 1 | Select frame in progress, for the sequencer |
| word_done | output | 1 | One-cycle pulse per committed word |
| word_addr | output | 4 | Address of the committed word |
| word_imm | output | 1 | Immediate flag of the committed word |

## Verification
The assertions assume that the serial clock runs at least four times slower than the system clock. Under that assumption two committed words are always many cycles apart, and a write never lands in the cycle right after another write. They also assume that select and data are stable around each serial-clock rising edge, so the synchronized samples match the bits sent. The stimulus drives every link pin on the falling system-clock edge and holds each serial-clock phase for four system cycles. Select changes only while the serial clock is low and at least four cycles away from one of its rising edges.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int WORD_BITS = 24;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 4;
    localparam int CNT_W     = $clog2(WORD_BITS);
    localparam int LAST_BIT  = WORD_BITS - 1;

    // Bit order on the wire, most significant first.
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              rsv_zero;
        logic              mode_imm;
        logic              mode_xclk;
        logic              fill_zero;
    } cmd_word_t;

    typedef struct packed {
        logic imm;
        logic xclk;
    } mode_t;

    // A logic 1 from either the word or the pin selects the mode.
    function automatic logic mode_merge(input logic word_bit, input logic pin_bit);
        return word_bit | pin_bit;
    endfunction

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_prev <= RST_VAL;
        else     q_prev <= stg[STAGES-1];
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/scr_shift.sv
module scr_shift
    import scr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_lvl,
    input  logic      sel_prev,
    input  logic      sck_lvl,
    input  logic      sck_prev,
    input  logic      sdi_lvl,
    input  logic      hold,
    output logic      word_vld,
    output cmd_word_t word_q,
    output logic      frame_q
);

    logic                 sck_rise;
    logic                 sel_fall;
    logic                 in_frame;
    logic [CNT_W-1:0]     bit_cnt;
    logic [WORD_BITS-1:0] sreg;
    logic [WORD_BITS-1:0] sreg_nxt;

    assign sck_rise = sck_lvl & ~sck_prev;
    assign sel_fall = ~sel_lvl & sel_prev;
    assign in_frame = ~sel_lvl & ~hold;
    assign sreg_nxt = {sreg[WORD_BITS-2:0], sdi_lvl};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            sreg     <= '0;
            word_vld <= 1'b0;
            word_q   <= '0;
            frame_q  <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            frame_q  <= in_frame;
            if (!in_frame || sel_fall) begin
                // Leftover bits of an unfinished word are dropped here.
                bit_cnt <= '0;
            end else if (sck_rise) begin
                sreg <= sreg_nxt;
                if (bit_cnt == CNT_W'(LAST_BIT)) begin
                    bit_cnt  <= '0;
                    word_vld <= 1'b1;
                    word_q   <= cmd_word_t'(sreg_nxt);
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/scr_decode.sv
module scr_decode
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  cmd_word_t         word_d,
    input  logic              imm_pin,
    input  logic              xclk_pin,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              word_done,
    output logic [ADDR_W-1:0] word_addr,
    output logic              word_imm,
    output logic              imm_eff,
    output logic              xclk_eff
);

    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            word_done <= 1'b0;
            word_addr <= '0;
            word_imm  <= 1'b0;
        end else begin
            mem_we    <= word_vld;
            word_done <= word_vld;
            if (word_vld) begin
                mode_q.imm  <= word_d.mode_imm;
                mode_q.xclk <= word_d.mode_xclk;
                mem_addr    <= word_d.addr;
                mem_wdata   <= word_d.data;
                word_addr   <= word_d.addr;
                word_imm    <= mode_merge(word_d.mode_imm, imm_pin);
            end
        end
    end

    assign imm_eff  = mode_merge(mode_q.imm, imm_pin);
    assign xclk_eff = mode_merge(mode_q.xclk, xclk_pin);

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import scr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              imm_pin,
    input  logic              xclk_pin,
    input  logic              fill_busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              imm_eff,
    output logic              xclk_eff,
    output logic              frame_active,
    output logic              word_done,
    output logic [ADDR_W-1:0] word_addr,
    output logic              word_imm
);

    localparam int PINS = 3;

    logic [PINS-1:0] pins_q;
    logic [PINS-1:0] pins_p;
    logic            word_vld;
    cmd_word_t       word_w;

    scr_sync #(
        .W       (PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk    (clk),
        .rst    (rst),
        .d      ({sel_n, sck, sdi}),
        .q      (pins_q),
        .q_prev (pins_p)
    );

    scr_shift shift_i (
        .clk      (clk),
        .rst      (rst),
        .sel_lvl  (pins_q[2]),
        .sel_prev (pins_p[2]),
        .sck_lvl  (pins_q[1]),
        .sck_prev (pins_p[1]),
        .sdi_lvl  (pins_q[0]),
        .hold     (fill_busy),
        .word_vld (word_vld),
        .word_q   (word_w),
        .frame_q  (frame_active)
    );

    scr_decode decode_i (
        .clk       (clk),
        .rst       (rst),
        .word_vld  (word_vld),
        .word_d    (word_w),
        .imm_pin   (imm_pin),
        .xclk_pin  (xclk_pin),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .word_done (word_done),
        .word_addr (word_addr),
        .word_imm  (word_imm),
        .imm_eff   (imm_eff),
        .xclk_eff  (xclk_eff)
    );

endmodule

// File: rtl/scr_checker.sv
module scr_checker (
    input logic       clk,
    input logic       rst,
    input logic       imm_pin,
    input logic       xclk_pin,
    input logic       fill_busy,
    input logic       mem_we,
    input logic [3:0] mem_addr,
    input logic       imm_eff,
    input logic       xclk_eff,
    input logic       frame_active,
    input logic       word_done,
    input logic [3:0] word_addr,
    input logic       word_imm
);

    // R4: words are at least 24 serial clocks apart, so a write never repeats at once
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R4: done pulse and write strobe travel together
    a_r4_done_with_write: assert property (@(posedge clk) disable iff (rst)
        word_done |-> (mem_we && word_addr == mem_addr));

    // R9: nothing sampled during a fill reaches the memory
    a_r9_busy_no_write: assert property (@(posedge clk) disable iff (rst)
        $past(fill_busy) |-> !mem_we);

    // R9: no frame reported during a fill
    a_r9_busy_no_frame: assert property (@(posedge clk) disable iff (rst)
        $past(fill_busy) |-> !frame_active);

    // R6: the pin alone forces the immediate flag
    a_r6_imm_pin_wins: assert property (@(posedge clk) disable iff (rst)
        imm_pin |-> imm_eff);

    // R7: the pin alone forces the external clock flag
    a_r7_xclk_pin_wins: assert property (@(posedge clk) disable iff (rst)
        xclk_pin |-> xclk_eff);

    // R6: the committed word reports the pin's request
    a_r6_word_imm_pin: assert property (@(posedge clk) disable iff (rst)
        (word_done && $past(imm_pin)) |-> word_imm);

    // R6: stored mode bit only moves with a write
    a_r6_mode_holds: assert property (@(posedge clk) disable iff (rst)
        (!mem_we && !imm_pin && !$past(imm_pin) && !$past(rst)) |-> $stable(imm_eff));

endmodule

bind serial_cmd_rx scr_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .imm_pin      (imm_pin),
    .xclk_pin     (xclk_pin),
    .fill_busy    (fill_busy),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .imm_eff      (imm_eff),
    .xclk_eff     (xclk_eff),
    .frame_active (frame_active),
    .word_done    (word_done),
    .word_addr    (word_addr),
    .word_imm     (word_imm)
);

// File: tb/serial_cmd_rx_tb_top.sv
module serial_cmd_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        imm_pin = 1'b0;
    logic        xclk_pin = 1'b0;
    logic        fill_busy = 1'b0;
    logic        mem_we;
    logic [3:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        imm_eff;
    logic        xclk_eff;
    logic        frame_active;
    logic        word_done;
    logic [3:0]  word_addr;
    logic        word_imm;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // Write monitor
    int          wr_cnt = 0;
    logic [15:0] wr_data [8];
    logic [3:0]  wr_addr [8];
    logic        wr_imm  [8];

    always #2.5 clk = ~clk;

    serial_cmd_rx dut_i (
        .clk          (clk),
        .rst          (rst),
        .sel_n        (sel_n),
        .sck          (sck),
        .sdi          (sdi),
        .imm_pin      (imm_pin),
        .xclk_pin     (xclk_pin),
        .fill_busy    (fill_busy),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .imm_eff      (imm_eff),
        .xclk_eff     (xclk_eff),
        .frame_active (frame_active),
        .word_done    (word_done),
        .word_addr    (word_addr),
        .word_imm     (word_imm)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst && mem_we) begin
            wr_data[wr_cnt % 8] <= mem_wdata;
            wr_addr[wr_cnt % 8] <= mem_addr;
            wr_imm[wr_cnt % 8]  <= word_imm;
            wr_cnt <= wr_cnt + 1;
        end
        if (cycles > 150000 && !done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    // {word[23:0], imm_pin, xclk_pin, exp_imm, exp_xclk}
    localparam logic [27:0] VEC [6] = '{
        {24'h4F2C00, 1'b0, 1'b0, 1'b0, 1'b0},
        {24'hFFFFF4, 1'b0, 1'b0, 1'b1, 1'b0},
        {24'h000152, 1'b0, 1'b0, 1'b0, 1'b1},
        {24'h8000A0, 1'b1, 1'b0, 1'b1, 1'b0},
        {24'hC74AC0, 1'b0, 1'b1, 1'b0, 1'b1},
        {24'h281C3F, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [23:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sdi = v[23-i];
            sck = 1'b0;
            tick(4);
            sck = 1'b1;
            tick(4);
        end
        sck = 1'b0;
    endtask

    task automatic frame_one(input logic [23:0] w);
        sel_n = 1'b0;
        tick(4);
        shift_bits(w, 24);
        tick(4);
        sel_n = 1'b1;
        tick(12);
    endtask

    initial begin
        int base;
        tick(6);
        rst = 1'b0;
        tick(2);

        // R11 reset state
        check("R11 mem_we", mem_we, 0);
        check("R11 word_done", word_done, 0);
        check("R11 frame_active", frame_active, 0);
        check("R11 imm_eff", imm_eff, 0);
        check("R11 xclk_eff", xclk_eff, 0);

        // R1 R2 R3 R6 R7 R8: table of single-word frames
        for (int k = 0; k < 6; k++) begin
            logic [23:0] w;
            w = VEC[k][27:4];
            imm_pin  = VEC[k][3];
            xclk_pin = VEC[k][2];
            base = wr_cnt;
            frame_one(w);
            check("R4 one write per word", wr_cnt - base, 1);
            check("R1 R2 data field", wr_data[base % 8], w[23:8]);
            check("R3 address", wr_addr[base % 8], w[7:4]);
            check("R6 imm_eff", imm_eff, VEC[k][1]);
            check("R7 xclk_eff", xclk_eff, VEC[k][0]);
            check("R6 word_imm", wr_imm[base % 8], VEC[k][1]);
        end
        imm_pin = 1'b0;
        xclk_pin = 1'b0;

        // R7: clock bit must be resent; a word with it clear deselects
        frame_one(24'h123470);
        check("R7 xclk dropped", xclk_eff, 0);
        check("R6 imm dropped", imm_eff, 0);

        // R4 R10: three words in one frame
        base = wr_cnt;
        sel_n = 1'b0;
        tick(6);
        check("R10 frame high", frame_active, 1);
        shift_bits(24'hAAAA90, 24);
        shift_bits(24'h5555E0, 24);
        shift_bits(24'h0F0F14, 24);
        tick(4);
        sel_n = 1'b1;
        tick(12);
        check("R10 frame low", frame_active, 0);
        check("R4 three writes", wr_cnt - base, 3);
        check("R4 word0 data", wr_data[base % 8], 16'hAAAA);
        check("R4 word1 data", wr_data[(base + 1) % 8], 16'h5555);
        check("R4 word2 addr", wr_addr[(base + 2) % 8], 4'h1);
        check("R4 word2 mode", imm_eff, 1);

        // R5: 30 bits, the 6-bit tail is dropped; next frame aligns afresh
        base = wr_cnt;
        sel_n = 1'b0;
        tick(4);
        shift_bits(24'h1111B0, 24);
        shift_bits(24'hFFFFFF, 6);
        tick(4);
        sel_n = 1'b1;
        tick(12);
        check("R5 tail no write", wr_cnt - base, 1);
        frame_one(24'h2222C0);
        check("R5 realigned count", wr_cnt - base, 2);
        check("R5 realigned data", wr_data[(base + 1) % 8], 16'h2222);
        check("R5 realigned addr", wr_addr[(base + 1) % 8], 4'hC);

        // R9: link ignored while a fill runs
        fill_busy = 1'b1;
        tick(4);
        base = wr_cnt;
        sel_n = 1'b0;
        tick(6);
        check("R9 frame stays low", frame_active, 0);
        shift_bits(24'hDEAD16, 24);
        tick(4);
        sel_n = 1'b1;
        tick(12);
        check("R9 no write", wr_cnt - base, 0);
        check("R9 imm unchanged", imm_eff, 0);
        check("R9 xclk unchanged", xclk_eff, 0);
        fill_busy = 1'b0;
        tick(4);
        frame_one(24'hBEEF50);
        check("R9 works after fill", wr_data[base % 8], 16'hBEEF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule